// File: doc/BRIEF.md
# Delayed Auto-Repeat Key Controller

This block gives auto-repeat to a keyboard whose keys send a single strobe when pressed and nothing while they stay down. The block repeats a key by switching off the supply to the key matrix. Each time the supply comes back while a key is still held, the keyboard sees a fresh press and strobes again. The block only takes the strobe line in and drives the matrix-supply enable out. It also provides a lengthened copy of the strobe, for hosts that poll rather than catch short pulses.

After a strobe, a delay counter runs to its limit. The block then cuts the matrix supply for a few cycles. A fixed number of cycles after the supply returns, it looks at the lengthened strobe. If a re-strobe has arrived, the key is confirmed as held and repeat is armed. On the next time-out, the block switches the supply at the repeat rate: a short off phase, then a longer on phase. This continues until a supply restore passes without a strobe. The block then falls back to a supply that is continuously on.

Top module: `key_autorepeat`

## Requirements
- R1: While reset is high and in the idle state after it, `matrix_pwr_en` is 1 and `strobe_ext` is 0.
- R2: `key_strobe` passes through a two-flop synchronizer and a rising-edge detector. Each rising edge gives one internal pulse two clock edges after the edge that first samples it. The pulse clears the delay counter.
- R3: The delay counter counts up from 0 to DELAY_CYC and halts. When it reaches that value, `matrix_pwr_en` drops for exactly OFF_CYC cycles. Measured in clock edges after the edge that first samples the strobe, the drop comes at DELAY_CYC+3.
- R4: `strobe_ext` goes high on the edge after each internal pulse and stays high for STRETCH_CYC cycles. A new pulse restarts that interval.
- R5: LAG_CYC cycles after the matrix supply is restored, the block samples `strobe_ext`. If it is high, repeat is armed. If it is low, the block stays idle, so a brief tap causes exactly one supply drop.
- R6: In repeat mode, `matrix_pwr_en` is 0 for REP_LOW cycles and then 1 for REP_PERIOD-REP_LOW cycles, and this cycle repeats.
- R7: In repeat mode, a sample after a supply restore that finds `strobe_ext` low returns the block to idle with continuous supply. A later tap then gives only one drop again.
- R8: When a key is held, the first repeat drop follows the next delay time-out after arming. With a keyboard that answers a restore within one cycle, this is 2*DELAY_CYC+OFF_CYC+7 edges after the press is first sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| key_strobe | input | 1 | Keyboard strobe, asynchronous |
| matrix_pwr_en | output | 1 | Key-matrix supply enable, 1 = powered |
| strobe_ext | output | 1 | Lengthened strobe for polling hosts |

## Verification
Repeat mode is the hardest state to reach from the ports. It needs a keyboard that answers each supply restore with a new strobe, and then a second time-out that starts from that re-strobe. The bench therefore contains a small keyboard model that watches `matrix_pwr_en` and raises the strobe for two cycles on every rising edge of the supply while the key is held. One directed press then walks the block through arming, the exact cycle of the first repeat drop, several repeat periods, and the release back to idle.

// File: rtl/kar_pkg.sv
package kar_pkg;

    typedef enum logic [1:0] {
        AR_IDLE   = 2'd0,
        AR_ARMED  = 2'd1,
        AR_REPEAT = 2'd2
    } ar_state_e;

    // width needed to hold the value n
    function automatic int cw(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/kar_strobe_in.sv
module kar_strobe_in #(
    parameter int STRETCH_CYC = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe_async,
    output logic strobe_pulse,
    output logic strobe_ext
);
    import kar_pkg::*;

    localparam int SW = cw(STRETCH_CYC);
    localparam logic [SW-1:0] ST_LOAD = SW'(STRETCH_CYC);

    logic [2:0]    sync_q;
    logic [SW-1:0] str_cnt;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[1:0], strobe_async};
    end

    assign strobe_pulse = sync_q[1] & ~sync_q[2];

    always_ff @(posedge clk) begin
        if (rst)                 str_cnt <= '0;
        else if (strobe_pulse)   str_cnt <= ST_LOAD;
        else if (str_cnt != '0)  str_cnt <= str_cnt - 1'b1;
    end

    assign strobe_ext = (str_cnt != '0);

endmodule

// File: rtl/kar_delay_timer.sv
module kar_delay_timer #(
    parameter int DELAY_CYC = 40,
    parameter int DW        = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    output logic [DW-1:0] count,
    output logic          tc_rise
);
    localparam logic [DW-1:0] TOP = DW'(DELAY_CYC);

    logic tc_q;
    logic at_top;

    assign at_top = (count == TOP);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= TOP;
            tc_q  <= 1'b1;
        end else begin
            tc_q <= at_top;
            if (clear)        count <= '0;
            else if (!at_top) count <= count + 1'b1;
        end
    end

    assign tc_rise = at_top & ~tc_q;

endmodule

// File: rtl/kar_repeat_fsm.sv
module kar_repeat_fsm
    import kar_pkg::*;
#(
    parameter int OFF_CYC    = 3,
    parameter int LAG_CYC    = 6,
    parameter int REP_PERIOD = 16,
    parameter int REP_LOW    = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tc_rise,
    input  logic      strobe_ext,
    output logic      pwr_en,
    output logic      sample_evt,
    output ar_state_e state
);
    localparam int OW = cw(OFF_CYC);
    localparam int LW = cw(LAG_CYC);
    localparam int PW = cw(REP_PERIOD);
    localparam logic [OW-1:0] OFF_LOAD = OW'(OFF_CYC);
    localparam logic [LW-1:0] LAG_LOAD = LW'(LAG_CYC);
    localparam logic [PW-1:0] PH_LAST  = PW'(REP_PERIOD - 1);
    localparam logic [PW-1:0] PH_LOW   = PW'(REP_LOW);
    localparam logic [PW-1:0] PH_RISE  = PW'(REP_LOW - 1);

    logic [OW-1:0] off_cnt;
    logic [LW-1:0] lag_cnt;
    logic [PW-1:0] phase;

    assign sample_evt = (lag_cnt == LW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= AR_IDLE;
            off_cnt <= '0;
            lag_cnt <= '0;
            phase   <= '0;
        end else begin
            if (off_cnt != '0) off_cnt <= off_cnt - 1'b1;
            if (lag_cnt != '0) lag_cnt <= lag_cnt - 1'b1;
            // sampling window opens when the supply comes back
            if (state != AR_REPEAT && off_cnt == OW'(1)) lag_cnt <= LAG_LOAD;
            if (state == AR_REPEAT) begin
                phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
                if (phase == PH_RISE) lag_cnt <= LAG_LOAD;
            end
            unique case (state)
                AR_IDLE: begin
                    if (sample_evt && strobe_ext) state <= AR_ARMED;
                    if (tc_rise) off_cnt <= OFF_LOAD;
                end
                AR_ARMED: begin
                    if (tc_rise) begin
                        state <= AR_REPEAT;
                        phase <= '0;
                    end else if (sample_evt && !strobe_ext) begin
                        state <= AR_IDLE;
                    end
                end
                AR_REPEAT: begin
                    if (sample_evt && !strobe_ext) begin
                        state <= AR_IDLE;
                        phase <= '0;
                    end
                end
                default: state <= AR_IDLE;
            endcase
        end
    end

    assign pwr_en = (state == AR_REPEAT) ? (phase >= PH_LOW) : (off_cnt == '0);

endmodule

// File: rtl/key_autorepeat.sv
module key_autorepeat
    import kar_pkg::*;
#(
    parameter int DELAY_CYC   = 500000,
    parameter int OFF_CYC     = 8,
    parameter int LAG_CYC     = 64,
    parameter int STRETCH_CYC = 10000,
    parameter int REP_PERIOD  = 100000,
    parameter int REP_LOW     = 20000
) (
    input  logic clk,
    input  logic rst,
    input  logic key_strobe,
    output logic matrix_pwr_en,
    output logic strobe_ext
);
    localparam int DW = cw(DELAY_CYC);

    logic          strobe_pulse;
    logic [DW-1:0] dly_cnt;
    logic          tc_rise;
    logic          sample_evt;
    ar_state_e     st;

    kar_strobe_in #(.STRETCH_CYC(STRETCH_CYC)) u_in (
        .clk          (clk),
        .rst          (rst),
        .strobe_async (key_strobe),
        .strobe_pulse (strobe_pulse),
        .strobe_ext   (strobe_ext)
    );

    kar_delay_timer #(.DELAY_CYC(DELAY_CYC), .DW(DW)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .clear   (strobe_pulse),
        .count   (dly_cnt),
        .tc_rise (tc_rise)
    );

    kar_repeat_fsm #(
        .OFF_CYC    (OFF_CYC),
        .LAG_CYC    (LAG_CYC),
        .REP_PERIOD (REP_PERIOD),
        .REP_LOW    (REP_LOW)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .tc_rise    (tc_rise),
        .strobe_ext (strobe_ext),
        .pwr_en     (matrix_pwr_en),
        .sample_evt (sample_evt),
        .state      (st)
    );

endmodule

// File: rtl/kar_checker.sv
module kar_checker
    import kar_pkg::*;
#(
    parameter int DELAY = 40,
    parameter int CW    = 6
) (
    input logic          clk,
    input logic          rst,
    input logic          strobe_pulse,
    input logic          strobe_ext,
    input logic [CW-1:0] dly_cnt,
    input logic          tc_rise,
    input logic          sample_evt,
    input logic          matrix_pwr_en,
    input ar_state_e     st
);
    localparam logic [CW-1:0] TOP = CW'(DELAY);

    a_r2_pulse_clears: assert property (@(posedge clk) disable iff (rst)
        strobe_pulse |=> (dly_cnt == '0));

    a_r3_counter_halts: assert property (@(posedge clk) disable iff (rst)
        (dly_cnt == TOP && !strobe_pulse) |=> (dly_cnt == TOP));

    a_r3_timeout_drops: assert property (@(posedge clk) disable iff (rst)
        (tc_rise && st == AR_IDLE) |=> !matrix_pwr_en);

    a_r4_ext_follows: assert property (@(posedge clk) disable iff (rst)
        strobe_pulse |=> strobe_ext);

    a_r1_supply_stays: assert property (@(posedge clk) disable iff (rst)
        (st != AR_REPEAT && matrix_pwr_en && !tc_rise) |=> matrix_pwr_en);

    a_r7_repeat_holds: assert property (@(posedge clk) disable iff (rst)
        (st == AR_REPEAT && !sample_evt) |=> (st == AR_REPEAT));

endmodule

bind key_autorepeat kar_checker #(.DELAY(DELAY_CYC), .CW(DW)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .strobe_pulse  (strobe_pulse),
    .strobe_ext    (strobe_ext),
    .dly_cnt       (dly_cnt),
    .tc_rise       (tc_rise),
    .sample_evt    (sample_evt),
    .matrix_pwr_en (matrix_pwr_en),
    .st            (st)
);

// File: tb/tb_key_autorepeat.sv
module tb_key_autorepeat;

    localparam int CLK_PERIOD = 10;
    localparam int D   = 40;
    localparam int OFF = 3;
    localparam int LAG = 6;
    localparam int STR = 12;
    localparam int PER = 16;
    localparam int LOW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic man_s = 1'b0;
    int   man_left = 0;
    logic key_held = 1'b0;
    int   kb_left = 0;
    logic pwr_prev = 1'b1;
    logic key_strobe;
    logic matrix_pwr_en;
    logic strobe_ext;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign key_strobe = man_s | (kb_left != 0);

    key_autorepeat #(
        .DELAY_CYC(D), .OFF_CYC(OFF), .LAG_CYC(LAG),
        .STRETCH_CYC(STR), .REP_PERIOD(PER), .REP_LOW(LOW)
    ) dut (
        .clk(clk), .rst(rst), .key_strobe(key_strobe),
        .matrix_pwr_en(matrix_pwr_en), .strobe_ext(strobe_ext)
    );

    // keyboard model: a held key re-strobes whenever the matrix supply returns
    always @(negedge clk) begin
        pwr_prev <= matrix_pwr_en;
        if (rst) kb_left <= 0;
        else if (key_held && matrix_pwr_en && !pwr_prev) kb_left <= 2;
        else if (kb_left != 0) kb_left <= kb_left - 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        if (man_left > 0) begin
            man_left--;
            if (man_left == 0) man_s = 1'b0;
        end
    endtask

    task automatic press(input bit held);
        tick();
        key_held = held;
        man_s = 1'b1;
        man_left = 2;
    endtask

    task automatic wait_fall(output int n);
        n = 0;
        do begin tick(); n++; end while (matrix_pwr_en && n < 1000);
    endtask

    task automatic low_width(output int w);
        w = 0;
        while (!matrix_pwr_en && w < 1000) begin w++; tick(); end
    endtask

    task automatic do_reset();
        rst = 1'b1; key_held = 1'b0; man_s = 1'b0; man_left = 0;
        repeat (3) tick();
        rst = 1'b0;
        tick();
    endtask

    task automatic test_reset();
        rst = 1'b1;
        repeat (3) tick();
        chk(matrix_pwr_en == 1'b1, "R1 pwr in reset", matrix_pwr_en, 1);
        chk(strobe_ext == 1'b0, "R1 ext in reset", strobe_ext, 0);
        rst = 1'b0;
        repeat (20) tick();
        chk(matrix_pwr_en == 1'b1, "R1 pwr idle", matrix_pwr_en, 1);
        chk(strobe_ext == 1'b0, "R1 ext idle", strobe_ext, 0);
    endtask

    task automatic test_stretch();
        int n, w;
        do_reset();
        press(1'b0);
        n = 0;
        do begin tick(); n++; end while (!strobe_ext && n < 100);
        chk(n == 3, "R2 sync latency", n, 3);
        w = 0;
        while (strobe_ext && w < 100) begin w++; tick(); end
        chk(w == STR, "R4 ext width", w, STR);
    endtask

    task automatic test_retrigger();
        int n, w;
        do_reset();
        press(1'b0);
        repeat (5) tick();
        press(1'b0);
        n = 0;
        while (!strobe_ext && n < 100) begin tick(); n++; end
        w = 0;
        while (strobe_ext && w < 100) begin w++; tick(); end
        chk(w == STR + 3, "R4 retrigger width", w, STR + 3);
    endtask

    task automatic test_tap();
        int n, w, lows;
        do_reset();
        press(1'b0);
        wait_fall(n);
        chk(n == D + 4, "R3 drop delay", n, D + 4);
        low_width(w);
        chk(w == OFF, "R3 drop width", w, OFF);
        lows = 0;
        repeat (150) begin tick(); if (!matrix_pwr_en) lows++; end
        chk(lows == 0, "R5 tap single drop", lows, 0);
    endtask

    task automatic test_hold();
        int n1, w, n2, lows;
        do_reset();
        press(1'b1);
        wait_fall(n1);
        chk(n1 == D + 4, "R3 held first drop", n1, D + 4);
        low_width(w);
        chk(w == OFF, "R3 held drop width", w, OFF);
        wait_fall(n2);
        chk(n1 + w + n2 == 2*D + OFF + 8, "R8 repeat start", n1 + w + n2, 2*D + OFF + 8);
        for (int k = 0; k < 3; k++) begin
            low_width(w);
            chk(w == LOW, "R6 repeat low", w, LOW);
            wait_fall(n2);
            chk(n2 == PER - LOW, "R6 repeat high", n2, PER - LOW);
        end
        key_held = 1'b0;
        repeat (D + 4*PER) tick();
        lows = 0;
        repeat (4*PER) begin tick(); if (!matrix_pwr_en) lows++; end
        chk(lows == 0, "R7 release idle", lows, 0);
        // armed state must be gone: a tap gives one drop only
        press(1'b0);
        wait_fall(n1);
        chk(n1 == D + 4, "R7 tap after release", n1, D + 4);
        low_width(w);
        lows = 0;
        repeat (150) begin tick(); if (!matrix_pwr_en) lows++; end
        chk(lows == 0, "R5 R7 no repeat", lows, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        test_reset();
        test_stretch();
        test_retrigger();
        test_tap();
        test_hold();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule